// File: doc/BRIEF.md
# Two-to-One Image Rescaling Unit

This unit sits in a pixel stream ahead of a correlation engine and changes the scale of each incoming image by a factor of two. A two-bit mode input chooses one of three behaviours. In pass mode the stream goes through unchanged. In halving mode each 2x2 block of input pixels becomes one output pixel, the rounded mean of the four. In doubling mode every input pixel is emitted twice along the row and every input row is emitted twice.

Pixels arrive in raster order, one per accepted cycle, with start-of-row and start-of-frame marks, and leave in raster order with marks of their own. The input row length and the input row count are programmable from 1 to 128. When halving an image whose width or height is odd, the unit extends the image at the edge: the last column or last row is paired with itself. When doubling, the unit stores each input row in a single internal row store. It lowers its ready output while it emits the horizontal repeats and the second copy of the row. Mode and sizes must be held constant while a frame is in flight.

Top module: `pix_rescale2`

## Requirements
- R1: While reset is asserted and after it is released with no input, `out_valid`, `out_sor` and `out_sof` are low and `in_ready` is high.
- R2: With `mode` 0 or 3 (pass), every accepted pixel appears on `out_pix` one cycle later with `out_valid`, and `out_sor`/`out_sof` copy `in_sor`/`in_sof`.
- R3: With `mode` 1 (halve), each output pixel equals (p00+p01+p10+p11+2)>>2 over one 2x2 input block. It is emitted in the cycle after the block's bottom-right pixel is accepted. A frame yields ceil(N/2) pixels per row and ceil(M/2) rows, where N is `row_len` and M is `row_cnt`.
- R4: When halving with an odd `row_len`, the last column of each pair of rows is paired with itself, so the last output pixel of a row is (2*pa+2*pb+2)>>2.
- R5: When halving with an odd `row_cnt`, the last input row is paired with itself, and its outputs are emitted as that row's pixels complete.
- R6: `in_ready` is high in any mode other than 2. With `mode` 2 (double), an accepted pixel is output in each of the next two cycles, and `in_ready` is low in the first of them.
- R7: In doubling mode, after the last pixel of an input row is accepted, `in_ready` stays low for 1+2N cycles. Meanwhile the row is replayed as 2N pixels, each stored pixel emitted twice, so each input row gives two output rows of 2N pixels.
- R8: `out_sor` marks the first pixel of every output row and `out_sof` only the first pixel of a frame. Both are high only together with `out_valid`, and `out_sof` implies `out_sor`.
- R9: An accepted pixel with `in_sof` high is taken as row 0, column 0 of a new frame, whatever the position reached in the previous frame.
- R10: `row_len` and `row_cnt` hold the plain count, 1 to 128, and the full range of 128 works in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode | input | 2 | 0/3 pass, 1 halve, 2 double |
| row_len | input | 8 | Input pixels per row, 1..128 |
| row_cnt | input | 8 | Input rows per frame, 1..128 |
| in_valid | input | 1 | Input pixel present |
| in_sor | input | 1 | Input pixel starts a row |
| in_sof | input | 1 | Input pixel starts a frame |
| in_pix | input | 8 | Input pixel, unsigned |
| in_ready | output | 1 | Unit accepts the input pixel this cycle |
| out_valid | output | 1 | Output pixel present |
| out_sor | output | 1 | Output pixel starts a row |
| out_sof | output | 1 | Output pixel starts a frame |
| out_pix | output | 8 | Output pixel, unsigned |

## Verification
The assertions assume that `mode` never changes while a frame is in progress or while a doubled row is still being replayed. The echo and pass-latency properties compare an output against the input one cycle earlier, and a mode change in between would break them. The assertions also assume that no pixel is offered in the two cycles after reset release, while the internal reset is still held. The stimulus changes the mode and sizes only after the input has been idle and all expected output has drained. It waits several cycles after reset before sending, and it always marks the first pixel of each frame with `in_sof`.

// File: rtl/pix_rescale2_pkg.sv
`timescale 1ns/1ps
package pix_rescale2_pkg;
  // mode input encoding
  typedef enum logic [1:0] {
    MODE_PASS     = 2'd0,
    MODE_HALF     = 2'd1,
    MODE_DOUBLE   = 2'd2,
    MODE_PASS_ALT = 2'd3
  } scale_mode_e;

  // doubling sequencer: take a pixel, echo it, replay the stored row
  typedef enum logic [1:0] {
    DS_TAKE   = 2'd0,
    DS_ECHO   = 2'd1,
    DS_REPLAY = 2'd2
  } dbl_state_e;
endpackage

// File: rtl/pix_rescale2_pos.sv
`timescale 1ns/1ps
// Raster position tracker: column/row of the pixel presented this cycle.
module pix_rescale2_pos #(
  parameter int MAX_LEN = 128,
  localparam int PW = $clog2(MAX_LEN),
  localparam int LW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          sof,
  input  logic [LW-1:0] row_len,
  input  logic [LW-1:0] row_cnt,
  output logic [PW-1:0] col,
  output logic [PW-1:0] row,
  output logic          col_last,
  output logic          row_last
);
  logic [PW-1:0] col_q, row_q, col_d, row_d;

  always_comb begin
    col      = sof ? '0 : col_q;
    row      = sof ? '0 : row_q;
    col_last = ({1'b0, col} == row_len - LW'(1));
    row_last = ({1'b0, row} == row_cnt - LW'(1));
    if (col_last) begin
      col_d = '0;
      row_d = row_last ? '0 : row + PW'(1);
    end else begin
      col_d = col + PW'(1);
      row_d = row;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (step) begin
      col_q <= col_d;
      row_q <= row_d;
    end
  end
endmodule

// File: rtl/pix_rescale2_rowbuf.sv
`timescale 1ns/1ps
// Single row store: one write port, one combinational read port.
module pix_rescale2_rowbuf #(
  parameter int DEPTH = 128,
  parameter int W = 9,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pix_rescale2_avg.sv
`timescale 1ns/1ps
// Rounded mean of two horizontal pair sums: (a + b + 2) >> 2.
module pix_rescale2_avg #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W:0]   a,
  input  logic [PIX_W:0]   b,
  output logic [PIX_W-1:0] y
);
  logic [PIX_W+1:0] total;

  always_comb begin
    total = {1'b0, a} + {1'b0, b} + (PIX_W+2)'(2);
    y     = total[PIX_W+1:2];
  end
endmodule

// File: rtl/pix_rescale2.sv
`timescale 1ns/1ps
module pix_rescale2
  import pix_rescale2_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int MAX_LEN = 128,
  localparam int PW = $clog2(MAX_LEN),
  localparam int LW = PW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [LW-1:0]    row_len,
  input  logic [LW-1:0]    row_cnt,
  input  logic             in_valid,
  input  logic             in_sor,
  input  logic             in_sof,
  input  logic [PIX_W-1:0] in_pix,
  output logic             in_ready,
  output logic             out_valid,
  output logic             out_sor,
  output logic             out_sof,
  output logic [PIX_W-1:0] out_pix
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_i  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_i  <= rst_meta;
    end
  end

  scale_mode_e mode_e;
  logic        is_half, is_dbl, take;
  dbl_state_e  st_q, st_d;
  logic [LW-1:0] rep_q, rep_d;
  logic          last_q;
  logic [PIX_W-1:0] hold_q;
  logic [PW-1:0] col, row;
  logic          col_last, row_last;

  assign mode_e   = scale_mode_e'(mode);
  assign is_half  = (mode_e == MODE_HALF);
  assign is_dbl   = (mode_e == MODE_DOUBLE);
  assign in_ready = !is_dbl || (st_q == DS_TAKE);
  assign take     = in_valid && in_ready;

  pix_rescale2_pos #(.MAX_LEN(MAX_LEN)) u_pos (
    .clk(clk), .rst_n(rst_n_i), .step(take), .sof(in_sof),
    .row_len(row_len), .row_cnt(row_cnt),
    .col(col), .row(row), .col_last(col_last), .row_last(row_last)
  );

  // halving datapath: horizontal pair sum, vertical pairing via row store
  logic [PIX_W:0] hsum, rd_data, wr_data, vsum_top;
  logic           pair_done, half_emit, buf_we;
  logic [PW-1:0]  wr_addr, rd_addr;
  logic [PIX_W-1:0] avg_y;

  always_comb begin
    hsum      = col[0] ? ({1'b0, hold_q} + {1'b0, in_pix}) : {in_pix, 1'b0};
    pair_done = col[0] || col_last;
    half_emit = is_half && take && pair_done && (row[0] || row_last);
    vsum_top  = row[0] ? rd_data : hsum;
    if (is_dbl) begin
      buf_we  = take;
      wr_addr = col;
      wr_data = {1'b0, in_pix};
      rd_addr = rep_q[LW-1:1];
    end else begin
      buf_we  = is_half && take && pair_done && !row[0] && !row_last;
      wr_addr = {1'b0, col[PW-1:1]};
      wr_data = hsum;
      rd_addr = {1'b0, col[PW-1:1]};
    end
  end

  pix_rescale2_rowbuf #(.DEPTH(MAX_LEN), .W(PIX_W+1)) u_rowbuf (
    .clk(clk), .we(buf_we), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  pix_rescale2_avg #(.PIX_W(PIX_W)) u_avg (.a(vsum_top), .b(hsum), .y(avg_y));

  // doubling sequencer next state
  logic hold_en;
  logic [LW:0] rep_end;
  always_comb begin
    st_d    = st_q;
    rep_d   = rep_q;
    rep_end = {row_len, 1'b0} - (LW+1)'(1);
    hold_en = take && (is_dbl || !col[0]);
    if (!is_dbl) begin
      st_d = DS_TAKE;
    end else begin
      unique case (st_q)
        DS_TAKE:   if (take) st_d = DS_ECHO;
        DS_ECHO: begin
          if (last_q) begin
            st_d  = DS_REPLAY;
            rep_d = '0;
          end else begin
            st_d = DS_TAKE;
          end
        end
        DS_REPLAY: begin
          rep_d = rep_q + LW'(1);
          if ({1'b0, rep_q} == rep_end) st_d = DS_TAKE;
        end
        default:   st_d = DS_TAKE;
      endcase
    end
  end

  // output next state
  logic ov_d, osor_d, osof_d;
  logic [PIX_W-1:0] opix_d;
  always_comb begin
    ov_d   = 1'b0;
    osor_d = 1'b0;
    osof_d = 1'b0;
    opix_d = '0;
    if (is_half) begin
      if (half_emit) begin
        ov_d   = 1'b1;
        opix_d = avg_y;
        osor_d = (col[PW-1:1] == '0);
        osof_d = (col[PW-1:1] == '0) && (row[PW-1:1] == '0);
      end
    end else if (is_dbl) begin
      unique case (st_q)
        DS_TAKE: if (take) begin
          ov_d   = 1'b1;
          opix_d = in_pix;
          osor_d = (col == '0);
          osof_d = (col == '0) && (row == '0);
        end
        DS_ECHO: begin
          ov_d   = 1'b1;
          opix_d = hold_q;
        end
        DS_REPLAY: begin
          ov_d   = 1'b1;
          opix_d = rd_data[PIX_W-1:0];
          osor_d = (rep_q == '0);
        end
        default: ov_d = 1'b0;
      endcase
    end else begin
      ov_d   = take;
      opix_d = in_pix;
      osor_d = take && in_sor;
      osof_d = take && in_sof;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q      <= DS_TAKE;
      rep_q     <= '0;
      out_valid <= 1'b0;
      out_sor   <= 1'b0;
      out_sof   <= 1'b0;
      out_pix   <= '0;
    end else begin
      st_q      <= st_d;
      rep_q     <= rep_d;
      out_valid <= ov_d;
      out_sor   <= osor_d;
      out_sof   <= osof_d;
      out_pix   <= opix_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      hold_q <= '0;
      last_q <= 1'b0;
    end else if (hold_en) begin
      hold_q <= in_pix;
      last_q <= col_last;
    end
  end
endmodule

// File: rtl/pix_rescale2_chk.sv
`timescale 1ns/1ps
module pix_rescale2_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_ni,
  input logic [1:0]       mode,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_sof,
  input logic [PIX_W-1:0] in_pix,
  input logic             out_valid,
  input logic             out_sor,
  input logic             out_sof,
  input logic [PIX_W-1:0] out_pix
);
  p_flags_valid_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_sor || out_sof) |-> out_valid);

  p_sof_sor_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    out_sof |-> out_sor);

  p_pass_follow_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode != 2'd1 && mode != 2'd2 && in_valid)
      |=> (out_valid && out_pix == $past(in_pix) && out_sof == $past(in_sof)));

  p_ready_free_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode != 2'd2) |-> in_ready);

  p_echo_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == 2'd2 && in_valid && in_ready)
      |=> (!in_ready && out_valid && out_pix == $past(in_pix)));

  p_half_cause_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == 2'd1 && out_valid) |-> $past(in_valid));
endmodule

bind pix_rescale2 pix_rescale2_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_ni(rst_n_i), .mode(mode),
  .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof), .in_pix(in_pix),
  .out_valid(out_valid), .out_sor(out_sor), .out_sof(out_sof), .out_pix(out_pix)
);

// File: tb/pix_rescale2_bench.sv
`timescale 1ns/1ps
module pix_rescale2_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic [1:0] mode;
  logic [7:0] row_len, row_cnt;
  logic       in_valid, in_sor, in_sof;
  logic [7:0] in_pix;
  logic       in_ready, out_valid, out_sor, out_sof;
  logic [7:0] out_pix;

  pix_rescale2 u_pix_rescale2 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .row_len(row_len), .row_cnt(row_cnt),
    .in_valid(in_valid), .in_sor(in_sor), .in_sof(in_sof), .in_pix(in_pix),
    .in_ready(in_ready), .out_valid(out_valid), .out_sor(out_sor),
    .out_sof(out_sof), .out_pix(out_pix)
  );

  int checks = 0;
  int fails  = 0;
  string req = "R1";
  logic [9:0] exp_q[$];   // {sof, sor, pix}

  function automatic logic [7:0] pv(int r, int c, int seed);
    if (seed < 0) return 8'hFF;
    return 8'((r * 29 + c * 13 + seed * 71 + r * c * 3) & 255);
  endfunction

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s extra output: actual pix=%0d expected none", req, out_pix);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        if ({out_sof, out_sor, out_pix} !== e) begin
          fails++;
          $display("FAIL %s (flags R8): actual pix=%0d sor=%0d sof=%0d expected pix=%0d sor=%0d sof=%0d",
                   req, out_pix, out_sor, out_sof, e[7:0], e[8], e[9]);
        end
      end
    end
  end

  task automatic push_exp(logic sof, logic sor, logic [7:0] p);
    exp_q.push_back({sof, sor, p});
  endtask

  task automatic drive_one(logic [7:0] p, logic sor, logic sof);
    @(negedge clk);
    in_valid = 1'b1; in_pix = p; in_sor = sor; in_sof = sof;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic setup(logic [1:0] m, int n, int rows);
    @(negedge clk);
    in_valid = 1'b0;
    mode = m; row_len = 8'(n); row_cnt = 8'(rows);
    repeat (3) @(negedge clk);
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    for (int t = 0; t < 800 && exp_q.size() != 0; t++) @(negedge clk);
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s output count: actual missing=%0d expected missing=0", req, exp_q.size());
      exp_q.delete();
    end
  endtask

  task automatic half_expect(int n, int m, int seed);
    for (int rr = 0; rr < (m + 1) / 2; rr++)
      for (int cc = 0; cc < (n + 1) / 2; cc++) begin
        int r0, r1, c0, c1, s;
        r0 = 2 * rr; r1 = (2 * rr + 1 < m) ? 2 * rr + 1 : m - 1;
        c0 = 2 * cc; c1 = (2 * cc + 1 < n) ? 2 * cc + 1 : n - 1;
        s = pv(r0, c0, seed) + pv(r0, c1, seed) + pv(r1, c0, seed) + pv(r1, c1, seed);
        push_exp(rr == 0 && cc == 0, cc == 0, 8'((s + 2) >> 2));
      end
  endtask

  task automatic send_frame(int n, int m, int seed);
    for (int r = 0; r < m; r++)
      for (int c = 0; c < n; c++)
        drive_one(pv(r, c, seed), c == 0, r == 0 && c == 0);
  endtask

  task automatic run_half(int n, int m, int seed, string tag);
    req = tag;
    setup(2'd1, n, m);
    half_expect(n, m, seed);
    send_frame(n, m, seed);
    drain();
  endtask

  task automatic run_pass(logic [1:0] md, int n, int m, int seed);
    req = "R2";
    setup(md, n, m);
    for (int r = 0; r < m; r++)
      for (int c = 0; c < n; c++) push_exp(r == 0 && c == 0, c == 0, pv(r, c, seed));
    send_frame(n, m, seed);
    drain();
  endtask

  task automatic run_double(int n, int m, int seed, string tag);
    req = tag;
    setup(2'd2, n, m);
    for (int r = 0; r < m; r++) begin
      for (int c = 0; c < n; c++) begin
        push_exp(r == 0 && c == 0, c == 0, pv(r, c, seed));
        push_exp(1'b0, 1'b0, pv(r, c, seed));
      end
      for (int c = 0; c < n; c++) begin
        push_exp(1'b0, c == 0, pv(r, c, seed));
        push_exp(1'b0, 1'b0, pv(r, c, seed));
      end
    end
    for (int r = 0; r < m; r++)
      for (int c = 0; c < n; c++) begin
        drive_one(pv(r, c, seed), c == 0, r == 0 && c == 0);
        @(negedge clk);
        in_valid = 1'b0;
        checks++;
        if (in_ready !== 1'b0) begin
          fails++;
          $display("FAIL R6 ready after accept: actual=%0b expected=0", in_ready);
        end
        if (c == n - 1) begin
          int low;
          low = 1;
          while (1) begin
            @(negedge clk);
            if (in_ready) break;
            low++;
            if (low > 600) break;
          end
          checks++;
          if (low != 1 + 2 * n) begin
            fails++;
            $display("FAIL R7 ready-low cycles: actual=%0d expected=%0d", low, 1 + 2 * n);
          end
        end
      end
    drain();
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 2'd0; row_len = 8'd4; row_cnt = 8'd4;
    in_valid = 1'b0; in_sor = 1'b0; in_sof = 1'b0; in_pix = 8'd0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_sor !== 1'b0 || out_sof !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 in reset: actual v=%0b sor=%0b sof=%0b rdy=%0b expected 0 0 0 1",
               out_valid, out_sor, out_sof, in_ready);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 after reset: actual v=%0b rdy=%0b expected 0 1", out_valid, in_ready);
    end

    run_pass(2'd0, 5, 3, 1);
    run_pass(2'd3, 4, 2, 2);

    run_half(4, 4, 3, "R3");
    run_half(2, 2, 4, "R3");
    run_half(6, 6, -1, "R3");
    run_half(5, 4, 5, "R4");
    run_half(1, 2, 6, "R4");
    run_half(7, 3, 7, "R5");
    run_half(1, 1, 8, "R5");
    run_half(4, 5, 9, "R5");
    run_half(128, 3, 10, "R10");
    run_half(3, 128, 11, "R10");
    run_half(128, 128, 12, "R10");

    // R9: abandon a frame mid-row, then restart with a start-of-frame mark
    req = "R9";
    setup(2'd1, 4, 4);
    push_exp(1'b1, 1'b1, 8'((pv(0,0,13) + pv(0,1,13) + pv(1,0,13) + pv(1,1,13) + 2) >> 2));
    for (int c = 0; c < 4; c++) drive_one(pv(0, c, 13), c == 0, c == 0);
    for (int c = 0; c < 3; c++) drive_one(pv(1, c, 13), c == 0, 1'b0);
    half_expect(4, 4, 14);
    send_frame(4, 4, 14);
    drain();

    run_double(1, 1, 15, "R6");
    run_double(3, 2, 16, "R7");
    run_double(4, 3, 17, "R7");
    run_double(128, 2, 18, "R10");

    // R6: ready stays high once back in pass mode
    setup(2'd0, 4, 4);
    checks++;
    if (in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R6 ready outside doubling: actual=%0b expected=1", in_ready);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule